// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block takes received Ethernet frames from a byte stream and places them into memory buffers that software has set up in a small descriptor ring. The byte stream marks the first and last byte of each frame, and it carries an error flag that reports a bad CRC found upstream. Each descriptor holds a control/status word and a buffer address. Software sets the ownership bit and the buffer size, and can mark any entry as the last one in the ring. When a frame starts, the engine checks whether the descriptor it points at belongs to hardware. If so, each byte goes out on a byte-write port to the buffer address plus the byte's offset.

At the last byte the engine applies the receive filter. The filter looks at the destination address and at the runt and CRC conditions, and a 6-bit accept control decides the result. For an accepted frame, the engine rewrites the status word, hands the entry back to software, reports the writeback on a one-cycle strobe, and moves to the next entry. For a rejected frame, the descriptor keeps hardware ownership and is used again for the next frame. A frame that starts while the current descriptor belongs to software is dropped completely.

Top module: `rx_desc_wb`

## Requirements
- R1: After reset the ring index is 0, `buf_we` and `wb_valid` are low, and every descriptor status word reads 0.
- R2: When `sw_we` is high, the status word and buffer address of entry `sw_idx` are written. They read back on `rd_word0`/`rd_bufaddr` for `rd_idx` in the cycle after the write edge. If the engine writes back the same entry in the same cycle, the engine's writeback wins.
- R3: For a frame that starts on an owned descriptor, the byte at offset p is written one cycle later to buffer address plus p, but only while p is below the length limit. This happens whether or not the frame is later accepted.
- R4: The writeback status word has bit 31 (owner) cleared and bit 30 (ring end) unchanged. Bit 29 (first) and bit 28 (last) are set. Bits 21, 20 and 19 carry the error flags. Bits 13:0 carry the stored length. Bits 27:22 and 18:14 are 0.
- R5: After a writeback the index moves to the next entry. It goes to 0 instead when the written entry had bit 30 set, or when it was entry NDESC-1. The index changes only on a writeback.
- R6: If the current descriptor's bit 31 is 0 when a frame starts, the frame causes no buffer write and no writeback, and the index does not change.
- R7: The address filter checks the 48-bit destination address, whose first byte received is the low byte of `station_addr`. Control bit 0 accepts any address. Bit 1 accepts a match with `station_addr`. Bit 2 accepts multicast: the first byte's bit 0 is set and the address is not all ones. Bit 3 accepts the all-ones broadcast address. A rejected frame gets no writeback, its descriptor stays owned, and the index does not change.
- R8: A frame shorter than MIN_LEN (64) bytes sets status bit 20. Such a frame is rejected unless control bit 4 is set.
- R9: If `rx_err` is seen on any byte of a frame, status bit 19 is set. Such a frame is rejected unless control bit 5 is set.
- R10: The length limit is the smaller of the buffer size (status bits 13:3 times 8) and `max_len`. A longer frame is accepted without its extra bytes and reports the limit as its length.
- R11: Status bit 21 is the OR of the runt flag, the CRC flag and truncation.
- R12: `wb_valid` pulses in the cycle after the edge that takes the last byte of an accepted frame. In that cycle `wb_idx` and `wb_word0` show the entry and the word written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Byte on `rx_data` is valid |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | CRC error flag from upstream |
| ctl_accept | input | 6 | Accept control: all, station, multicast, broadcast, runt, error (bits 0..5) |
| max_len | input | 14 | Largest frame length stored |
| station_addr | input | 48 | Station address, first byte in bits 7:0 |
| sw_we | input | 1 | Software descriptor write |
| sw_idx | input | IW | Entry written by software |
| sw_word0 | input | 32 | Status/control word to write |
| sw_bufaddr | input | AW | Buffer address to write |
| rd_idx | input | IW | Entry shown on the read port |
| rd_word0 | output | 32 | Status word of `rd_idx` |
| rd_bufaddr | output | AW | Buffer address of `rd_idx` |
| cur_idx | output | IW | Current ring index |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | AW | Buffer byte address |
| buf_data | output | 8 | Buffer byte |
| wb_valid | output | 1 | Descriptor writeback strobe |
| wb_idx | output | IW | Entry written back |
| wb_word0 | output | 32 | Status word written back |

## Verification
Buffer writes and the writeback strobe each come out exactly one cycle after the clock edge that takes the input byte. The index and the status words on the read port change at that same edge. The bench drives inputs on the falling edge and records buffer writes and writeback strobes on the falling edge that follows. It checks the recorded counts and words two falling edges after the last byte of each frame, so every check reads results that have settled. For a rejected or dropped frame, the bench reads the descriptor's state back through the read port and the index output.

// File: rtl/rx_desc_wb.sv
`timescale 1ns/1ps
module rx_desc_wb #(
  parameter int NDESC   = 4,
  parameter int AW      = 32,
  parameter int MIN_LEN = 64,
  localparam int IW     = (NDESC > 1) ? $clog2(NDESC) : 1,
  localparam int LW     = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_err,
  input  logic [5:0]    ctl_accept,
  input  logic [LW-1:0] max_len,
  input  logic [47:0]   station_addr,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic [31:0]   sw_word0,
  input  logic [AW-1:0] sw_bufaddr,
  input  logic [IW-1:0] rd_idx,
  output logic [31:0]   rd_word0,
  output logic [AW-1:0] rd_bufaddr,
  output logic [IW-1:0] cur_idx,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_data,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx,
  output logic [31:0]   wb_word0
);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP} st_t;

  logic [31:0]   w0 [NDESC];
  logic [AW-1:0] ba [NDESC];
  st_t           st;
  logic [LW:0]   pos_q;
  logic [47:0]   da_q;
  logic          err_q;

  assign rd_word0   = w0[rd_idx];
  assign rd_bufaddr = ba[rd_idx];

  wire         cw_own = w0[cur_idx][31];
  wire         cw_eor = w0[cur_idx][30];
  wire [10:0]  cw_bsz = w0[cur_idx][13:3];
  wire [AW-1:0] cw_ba = ba[cur_idx];

  wire start  = rx_valid & rx_sof;
  wire active = rx_valid & (rx_sof ? cw_own : (st == S_RECV));
  wire finish = active & rx_eof;

  wire [LW:0] p     = start ? '0 : pos_q;
  wire [LW:0] total = (&p) ? p : p + 1'b1;
  wire [LW:0] bsz   = {1'b0, cw_bsz, 3'b000};
  wire [LW:0] mx    = {1'b0, max_len};
  wire [LW:0] lim   = (bsz < mx) ? bsz : mx;
  wire        store = active & (p < lim);

  logic [47:0] da_now;
  always_comb begin
    for (int k = 0; k < 6; k++) begin
      da_now[8*k +: 8] = start ? 8'h00 : da_q[8*k +: 8];
      if (active && p == (LW+1)'(k)) da_now[8*k +: 8] = rx_data;
    end
  end

  wire err_now = rx_err | (~start & err_q);
  wire runt    = total < (LW+1)'(MIN_LEN);
  wire trunc   = total > lim;
  wire res     = runt | err_now | trunc;
  wire [LW-1:0] slen = LW'(trunc ? lim : total);

  wire bcast   = &da_now;
  wire mcast   = da_now[0] & ~bcast;
  wire match   = da_now == station_addr;
  wire addr_ok = ctl_accept[0] | (ctl_accept[1] & match) |
                 (ctl_accept[2] & mcast) | (ctl_accept[3] & bcast);
  wire accept  = addr_ok & (~runt | ctl_accept[4]) & (~err_now | ctl_accept[5]);
  wire do_wb   = finish & accept;

  wire [31:0] wbw = {1'b0, cw_eor, 2'b11, 6'b0, res, runt, err_now, 5'b0, slen};
  wire [IW-1:0] nxt = (cw_eor || cur_idx == IW'(NDESC-1)) ? '0 : cur_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      pos_q <= '0;
      da_q  <= '0;
      err_q <= 1'b0;
    end else if (rx_valid) begin
      pos_q <= total;
      da_q  <= da_now;
      err_q <= err_now;
      if (rx_sof)      st <= rx_eof ? S_IDLE : (cw_own ? S_RECV : S_DROP);
      else if (rx_eof) st <= S_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        w0[i] <= '0;
        ba[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NDESC; i++) begin
        if (do_wb && cur_idx == IW'(i)) begin
          w0[i] <= wbw;
        end else if (sw_we && sw_idx == IW'(i)) begin
          w0[i] <= sw_word0;
          ba[i] <= sw_bufaddr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_idx  <= '0;
      buf_we   <= 1'b0;
      buf_addr <= '0;
      buf_data <= '0;
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_word0 <= '0;
    end else begin
      buf_we   <= store;
      buf_addr <= cw_ba + AW'(p);
      buf_data <= rx_data;
      wb_valid <= do_wb;
      wb_idx   <= cur_idx;
      wb_word0 <= wbw;
      if (do_wb) cur_idx <= nxt;
    end
  end

endmodule

// File: rtl/rx_desc_wb_chk.sv
`timescale 1ns/1ps
module rx_desc_wb_chk #(
  parameter int IW      = 2,
  parameter int MIN_LEN = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic          rx_eof,
  input logic [13:0]   max_len,
  input logic [IW-1:0] cur_idx,
  input logic          buf_we,
  input logic          wb_valid,
  input logic [IW-1:0] wb_idx,
  input logic [31:0]   wb_word0
);

  AST_WB_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (!wb_word0[31] && wb_word0[29] && wb_word0[28] &&
                  wb_word0[27:22] == 6'b0 && wb_word0[18:14] == 5'b0)); // R4

  AST_IDX_ONLY_ON_WB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> wb_valid); // R5

  AST_WB_IDX_WAS_CUR: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx == $past(cur_idx)); // R12

  AST_WB_AFTER_EOF: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(rx_valid && rx_eof)); // R12

  AST_RUNT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_word0[20]) |-> wb_word0[13:0] < 14'(MIN_LEN)); // R8

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_word0[13:0] <= $past(max_len)); // R10

  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && (wb_word0[20] || wb_word0[19])) |-> wb_word0[21]); // R11

  AST_WRITE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> $past(rx_valid)); // R3

endmodule

bind rx_desc_wb rx_desc_wb_chk #(.IW(IW), .MIN_LEN(MIN_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_eof(rx_eof),
  .max_len(max_len), .cur_idx(cur_idx), .buf_we(buf_we),
  .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_word0(wb_word0)
);

// File: tb/rx_desc_wb_bench.sv
`timescale 1ns/1ps
module rx_desc_wb_bench;
  localparam int NDESC = 4;
  localparam int IW = 2;
  localparam logic [47:0] STA = 48'h55_44_33_22_11_02;

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
  logic [7:0] rx_data = 0;
  logic [5:0] ctl_accept = 6'h02;
  logic [13:0] max_len = 14'd1536;
  logic sw_we = 0;
  logic [IW-1:0] sw_idx = 0, rd_idx = 0;
  logic [31:0] sw_word0 = 0;
  logic [31:0] sw_bufaddr = 0;
  logic [31:0] rd_word0, rd_bufaddr, buf_addr, wb_word0;
  logic [IW-1:0] cur_idx, wb_idx;
  logic buf_we, wb_valid;
  logic [7:0] buf_data;

  always #2 clk = ~clk;

  rx_desc_wb u_rx_desc_wb (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err), .ctl_accept(ctl_accept),
    .max_len(max_len), .station_addr(STA), .sw_we(sw_we), .sw_idx(sw_idx),
    .sw_word0(sw_word0), .sw_bufaddr(sw_bufaddr), .rd_idx(rd_idx),
    .rd_word0(rd_word0), .rd_bufaddr(rd_bufaddr), .cur_idx(cur_idx),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_word0(wb_word0)
  );

  int nchk = 0, nfail = 0;
  logic [7:0] frm [0:2047];
  int fbase = 0, nwr = 0, nbad = 0, nwb = 0;
  logic [31:0] wb_last;
  logic [IW-1:0] wb_last_idx;
  logic eor [NDESC];
  int exp_idx = 0;

  always @(negedge clk) begin
    if (buf_we) begin
      int off;
      off = int'(buf_addr) - fbase;
      nwr++;
      if (off < 0 || off > 2047 || buf_data !== frm[off]) nbad++;
    end
    if (wb_valid) begin
      nwb++;
      wb_last = wb_word0;
      wb_last_idx = wb_idx;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] addr_of(input int i);
    return 32'h1000 * (i + 1);
  endfunction

  function automatic logic [31:0] ew0(input logic e, input logic [2:0] fl, input logic [13:0] len);
    return {1'b0, e, 2'b11, 6'b0, fl, 5'b0, len};
  endfunction

  task automatic set_desc(input int i, input logic [31:0] w);
    @(negedge clk);
    sw_we = 1; sw_idx = IW'(i); sw_word0 = w; sw_bufaddr = addr_of(i);
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic refill(input int i);
    set_desc(i, {1'b1, eor[i], 16'b0, 14'd1536});
  endtask

  function automatic logic [7:0] da_byte(input int kind, input int k);
    case (kind)
      0: return STA[8*k +: 8];
      1: return (k == 5) ? 8'h56 : STA[8*k +: 8];
      2: return (k == 0) ? 8'h01 : ((k == 2) ? 8'h5e : 8'h00);
      default: return 8'hff;
    endcase
  endfunction

  task automatic send(input int len, input int kind, input bit crc);
    for (int p = 0; p < len; p++) frm[p] = (p < 6) ? da_byte(kind, p) : (8'(p) ^ 8'h5a);
    fbase = int'(addr_of(exp_idx));
    nwr = 0; nbad = 0; nwb = 0;
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      rx_valid = 1; rx_data = frm[p]; rx_sof = (p == 0); rx_eof = (p == len - 1);
      rx_err = crc && (p == len - 1);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_accept(input string req, input int writes, input logic [2:0] fl, input int len);
    int nxt;
    chk(nwr == writes && nbad == 0, "R3 byte writes", nwr, writes);
    chk(nwb == 1, {req, " writeback seen"}, nwb, 1);
    chk(wb_last == ew0(eor[exp_idx], fl, 14'(len)), {req, " R4 status word"}, wb_last, ew0(eor[exp_idx], fl, 14'(len)));
    chk(wb_last_idx == IW'(exp_idx), "R12 wb index", wb_last_idx, exp_idx);
    rd_idx = IW'(exp_idx); #1;
    chk(rd_word0 == wb_last, "R12 table matches strobe", rd_word0, wb_last);
    nxt = (eor[exp_idx] || exp_idx == NDESC - 1) ? 0 : exp_idx + 1;
    chk(cur_idx == IW'(nxt), "R5 ring advance", cur_idx, nxt);
    refill(exp_idx);
    exp_idx = nxt;
  endtask

  task automatic expect_reject(input string req, input int writes);
    chk(nwr == writes && nbad == 0, "R3 byte writes", nwr, writes);
    chk(nwb == 0, {req, " no writeback"}, nwb, 0);
    chk(cur_idx == IW'(exp_idx), {req, " index held"}, cur_idx, exp_idx);
    rd_idx = IW'(exp_idx); #1;
    chk(rd_word0[31] == 1'b1, {req, " still owned"}, rd_word0[31], 1);
  endtask

  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  ctl;
    logic [1:0]  kind;
    logic [13:0] len;
    logic        crc;
    logic        acc;
    logic [2:0]  fl;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{4'd7, 6'h02, 2'd0, 14'd64,  1'b0, 1'b1, 3'b000}, // R7 station match
    '{4'd7, 6'h02, 2'd1, 14'd64,  1'b0, 1'b0, 3'b000}, // R7 other unicast
    '{4'd7, 6'h01, 2'd1, 14'd70,  1'b0, 1'b1, 3'b000}, // R7 promiscuous
    '{4'd7, 6'h04, 2'd2, 14'd64,  1'b0, 1'b1, 3'b000}, // R7 multicast
    '{4'd7, 6'h02, 2'd2, 14'd64,  1'b0, 1'b0, 3'b000}, // R7 multicast off
    '{4'd7, 6'h08, 2'd3, 14'd80,  1'b0, 1'b1, 3'b000}, // R7 broadcast
    '{4'd7, 6'h04, 2'd3, 14'd64,  1'b0, 1'b0, 3'b000}, // R7 broadcast not multicast
    '{4'd8, 6'h02, 2'd0, 14'd40,  1'b0, 1'b0, 3'b000}, // R8 runt rejected
    '{4'd8, 6'h12, 2'd0, 14'd40,  1'b0, 1'b1, 3'b110}, // R8 runt kept
    '{4'd9, 6'h02, 2'd0, 14'd100, 1'b1, 1'b0, 3'b000}, // R9 crc rejected
    '{4'd9, 6'h22, 2'd0, 14'd100, 1'b1, 1'b1, 3'b101}, // R9 crc kept
    '{4'd11, 6'h32, 2'd0, 14'd20, 1'b1, 1'b1, 3'b111}  // R11 both flags
  };

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail + 1, nchk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < NDESC; i++) eor[i] = 1'b0;
    eor[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk(cur_idx == 0 && !buf_we && !wb_valid, "R1 reset outputs", {cur_idx, buf_we, wb_valid}, 0);
    rd_idx = 2; #1;
    chk(rd_word0 == 0, "R1 reset table", rd_word0, 0);
    rst_n = 1;
    refill(0);
    refill(1);
    rd_idx = 1; #1;
    chk(rd_word0 == 32'hC000_0600 && rd_bufaddr == 32'h2000, "R2 software write", rd_word0, 32'hC000_0600);

    for (int v = 0; v < 12; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
      ctl_accept = VEC[v].ctl;
      send(int'(VEC[v].len), int'(VEC[v].kind), VEC[v].crc);
      if (VEC[v].acc) expect_accept(tag, int'(VEC[v].len), VEC[v].fl, int'(VEC[v].len));
      else            expect_reject(tag, int'(VEC[v].len));
    end

    ctl_accept = 6'h02;
    max_len = 14'd100;
    send(120, 0, 0);
    expect_accept("R10 max_len cut", 100, 3'b100, 100); // R11 truncation sets summary
    max_len = 14'd1536;

    set_desc(exp_idx, {1'b1, eor[exp_idx], 16'b0, 14'd48});
    send(64, 0, 0);
    expect_accept("R10 buffer size cut", 48, 3'b100, 48);

    set_desc(0, 32'h0000_0600);
    set_desc(1, 32'h4000_0600);
    send(64, 0, 0);
    chk(nwr == 0 && nwb == 0, "R6 unowned dropped", nwr + nwb, 0);
    chk(cur_idx == IW'(exp_idx), "R6 index held", cur_idx, exp_idx);

    for (int i = 0; i < NDESC; i++) begin
      eor[i] = 1'b0;
      refill(i);
    end
    exp_idx = int'(cur_idx);
    for (int n = 0; n < NDESC + 1; n++) begin
      send(64, 0, 0);
      expect_accept("R5 wrap at last entry", 64, 3'b000, 64);
    end

    @(negedge clk);
    sw_we = 1; sw_idx = IW'(exp_idx); sw_word0 = 32'h8000_0600; sw_bufaddr = addr_of(exp_idx);
    rx_valid = 1; rx_sof = 1; rx_eof = 1; rx_data = 8'h02;
    ctl_accept = 6'h11;
    @(negedge clk);
    sw_we = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0;
    rd_idx = IW'(exp_idx); #1;
    chk(rd_word0 == ew0(1'b0, 3'b110, 14'd1), "R2 writeback wins over software", rd_word0, ew0(1'b0, 3'b110, 14'd1));

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule